// File: doc/BRIEF.md
# Redundant Command Word Receiver

This block sits behind a carrier-recovery front end. That front end supplies a serial bit stream, a one-cycle strobe for each recovered bit, and a flag that says the carrier is locked. Each accepted bit moves into a 16-bit window. After every new bit the block checks the window for a valid command word. A valid word has a fixed 8-bit preamble of `01110101` followed by a payload byte in which each of four payload bits is sent twice in adjacent positions. A word is rejected if any pair disagrees.

A valid word is a command. Three payload bits select one of eight output lines, and the fourth bit gives the level to write to that line. The lines are held in an addressable latch. The sender repeats commands with no handshake, so every command is idempotent. Repeating a command re-writes the same level, and each repeat raises the accept pulse again. The latch is written one clock after the bit that completes the word. This keeps the write away from the edge that samples the bit. Windows that were only partly filled before a loss of lock can never complete a word.

Top module: `cmdword_rx`

## Requirements
- R1: While `rst_n` is low, and on leaving reset, all eight `lines` are 0 and `accept` is 0.
- R2: A bit is taken in only on a clock where `bit_stb` and `lock` are both high. The first bit received of a word is the preamble's leftmost bit, and words are sent leftmost bit first.
- R3: A word is accepted only if its first eight bits equal `01110101`.
- R4: The last eight bits, in order of arrival, are W,W,X,X,Y,Y,Z,Z. The word is accepted only if both copies of each of W, X, Y and Z are equal. A rejected word leaves `lines` unchanged.
- R5: An accepted word writes Z to `lines[{W,X,Y}]`, with W as the address MSB. No other line changes.
- R6: The write happens at the clock edge that follows the edge that clocked in the word's last bit. At that edge `accept` goes high for exactly one cycle and `lines` shows the new value.
- R7: Sending the same word again leaves `lines` unchanged, and each repetition produces its own accept pulse.
- R8: While `lock` is low, strobes are ignored and no word is accepted. When lock returns, a word is accepted only after 16 new bits have been received, so bits from before the loss never count.
- R9: While `bit_stb` is low, `bit_in` has no effect. Toggling it between strobes does not change the word that is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered reference clock |
| rst_n | input | 1 | Active-low reset, clears latch and window |
| lock | input | 1 | Carrier lock flag from the front end |
| bit_stb | input | 1 | One-cycle strobe marking a valid recovered bit |
| bit_in | input | 1 | Recovered data bit, sampled with `bit_stb` |
| lines | output | 8 | Latched on/off outputs |
| accept | output | 1 | One-cycle pulse per accepted command word |

## Verification
The hardest case to reach from the ports is a window that still holds cleared positions after lock returns. The preamble starts with 0, so fifteen fresh bits shifted in behind the cleared zeros can form a perfect word unless the fill count stops them. The bench sends half a word, drops lock, and strobes junk while unlocked. It then sends exactly the fifteen trailing bits of a valid word and expects no accept. One more full word must then succeed. The exact edge of the write is probed separately by sampling `accept` and `lines` on the half cycle before, during and after the expected pulse.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int HDR_W   = 8;
  localparam int PAY_W   = 4;
  localparam int WORD_W  = HDR_W + 2 * PAY_W;
  localparam int ADDR_W  = PAY_W - 1;
  localparam int N_LINES = 1 << ADDR_W;
  localparam int FILL_W  = $clog2(WORD_W + 1);
  localparam logic [HDR_W-1:0] PREAMBLE = 8'b0111_0101;

  // every payload bit must arrive as two equal copies
  function automatic logic pairs_ok(input logic [2*PAY_W-1:0] body);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PAY_W; i++)
      if (body[2*i] != body[2*i+1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [PAY_W-1:0] payload(input logic [2*PAY_W-1:0] body);
    logic [PAY_W-1:0] p;
    for (int i = 0; i < PAY_W; i++) p[i] = body[2*i];
    return p;
  endfunction

  function automatic logic word_ok(input logic [WORD_W-1:0] w);
    return (w[WORD_W-1 -: HDR_W] == PREAMBLE) && pairs_ok(w[2*PAY_W-1:0]);
  endfunction
endpackage

// File: rtl/cmdrx_shifter.sv
module cmdrx_shifter
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              stb,
  input  logic              din,
  output logic [WORD_W-1:0] window,
  output logic              full,
  output logic              shift_ev
);
  logic [FILL_W-1:0] fill_q;
  logic              take;

  assign take = stb & lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window   <= '0;
      fill_q   <= '0;
      shift_ev <= 1'b0;
    end else if (!lock) begin
      window   <= '0;
      fill_q   <= '0;
      shift_ev <= 1'b0;
    end else begin
      shift_ev <= take;
      if (take) begin
        window <= {window[WORD_W-2:0], din};
        if (fill_q != FILL_W'(WORD_W)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign full = (fill_q == FILL_W'(WORD_W));
endmodule

// File: rtl/cmdrx_match.sv
module cmdrx_match
  import cmdrx_pkg::*;
(
  input  logic              [WORD_W-1:0] window,
  input  logic                           full,
  output logic                           hit,
  output logic              [ADDR_W-1:0] addr,
  output logic                           level
);
  logic [PAY_W-1:0] pay;

  assign pay   = payload(window[2*PAY_W-1:0]);
  assign hit   = full & word_ok(window);
  assign addr  = pay[PAY_W-1:1];
  assign level = pay[0];
endmodule

// File: rtl/cmdrx_latch.sv
module cmdrx_latch
  import cmdrx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic  [ADDR_W-1:0] addr,
  input  logic               level,
  output logic [N_LINES-1:0] q
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_cell
    logic sel;
    assign sel = we & (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[g] <= 1'b0;
      else if (sel) q[g] <= level;
    end
  end
endmodule

// File: rtl/cmdword_rx.sv
module cmdword_rx
  import cmdrx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               bit_stb,
  input  logic               bit_in,
  output logic [N_LINES-1:0] lines,
  output logic               accept
);
  logic [WORD_W-1:0] window;
  logic              full;
  logic              shift_ev_q;
  logic              hit;
  logic [ADDR_W-1:0] addr;
  logic              level;
  logic              write_ev;

  cmdrx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .lock(lock), .stb(bit_stb), .din(bit_in),
    .window(window), .full(full), .shift_ev(shift_ev_q)
  );

  cmdrx_match u_match (
    .window(window), .full(full), .hit(hit), .addr(addr), .level(level)
  );

  // write one edge after the shift, away from the sampling edge
  assign write_ev = shift_ev_q & lock & hit;

  cmdrx_latch u_latch (
    .clk(clk), .rst_n(rst_n), .we(write_ev), .addr(addr), .level(level),
    .q(lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept <= 1'b0;
    else        accept <= write_ev;
  end
endmodule

// File: rtl/cmdword_rx_chk.sv
module cmdword_rx_chk
  import cmdrx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               lock,
  input logic               accept,
  input logic [N_LINES-1:0] lines,
  input logic               shift_ev,
  input logic [WORD_W-1:0]  window
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (lines == '0) && !accept); // R1
  AST_ACCEPT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(shift_ev)); // R6
  AST_PREAMBLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(window[WORD_W-1 -: HDR_W]) == PREAMBLE); // R3
  AST_HOLD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(lines)); // R4
  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $countones(lines ^ $past(lines)) <= 1); // R5
  AST_NO_ACCEPT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !accept); // R8
endmodule

bind cmdword_rx cmdword_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .accept(accept), .lines(lines),
  .shift_ev(shift_ev_q), .window(window)
);

// File: tb/cmdword_rx_test.sv
module cmdword_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic       bit_stb = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] lines;
  logic       accept;

  int n_run = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  cmdword_rx uut (
    .clk(clk), .rst_n(rst_n), .lock(lock), .bit_stb(bit_stb), .bit_in(bit_in),
    .lines(lines), .accept(accept)
  );

  always @(negedge clk) if (accept) acc_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input int a, input bit v);
    logic [2:0] ad;
    ad = 3'(a);
    return {8'b0111_0101, ad[2], ad[2], ad[1], ad[1], ad[0], ad[0], v, v};
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0; bit_in = ~b;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 lines", lines, 0);
    check("R1 accept", accept, 0);
  endtask

  task automatic t_set_clear;
    int c0;
    c0 = acc_cnt;
    send_word(mk_word(5, 1)); model[5] = 1'b1;
    check("R5 set line 5", lines, model);
    send_word(mk_word(5, 0)); model[5] = 1'b0;
    check("R5 clear line 5", lines, model);
    check("R2 accepts", acc_cnt - c0, 2);
  endtask

  task automatic t_all;
    int c0;
    c0 = acc_cnt;
    for (int a = 0; a < 8; a++) begin
      send_word(mk_word(a, 1)); model[a] = 1'b1;
      check("R5 set walk", lines, model);
    end
    for (int a = 7; a >= 0; a -= 2) begin
      send_word(mk_word(a, 0)); model[a] = 1'b0;
      check("R5 clear walk", lines, model);
    end
    check("R5 walk accepts", acc_cnt - c0, 12);
  endtask

  task automatic t_timing;
    logic [15:0] w;
    w = mk_word(6, 1);
    for (int i = 15; i >= 1; i--) send_bit(w[i]);
    @(negedge clk); bit_in = w[0]; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    check("R6 no early accept", accept, 0);
    check("R6 no early write", lines, model);
    model[6] = 1'b1;
    @(negedge clk);
    check("R6 accept high", accept, 1);
    check("R6 write visible", lines, model);
    @(negedge clk);
    check("R6 one-cycle pulse", accept, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_repeat;
    int c0;
    c0 = acc_cnt;
    for (int k = 0; k < 3; k++) send_word(mk_word(6, 1));
    check("R7 repeat unchanged", lines, model);
    check("R7 repeat accepts", acc_cnt - c0, 3);
  endtask

  task automatic t_bad_header;
    int c0;
    logic [15:0] w;
    c0 = acc_cnt;
    w = mk_word(2, 1); w[8] = 1'b0;
    send_word(w);
    w = mk_word(3, 1); w[15] = 1'b1;
    send_word(w);
    check("R3 bad preamble no accept", acc_cnt - c0, 0);
    check("R3 bad preamble lines", lines, model);
  endtask

  task automatic t_bad_pair;
    int c0;
    logic [15:0] w;
    c0 = acc_cnt;
    w = mk_word(1, 1); w[4] = ~w[4];
    send_word(w);
    w = mk_word(4, 1); w[0] = 1'b0;
    send_word(w);
    check("R4 mismatched pair no accept", acc_cnt - c0, 0);
    check("R4 mismatched pair lines", lines, model);
  endtask

  task automatic t_lock;
    int c0;
    logic [15:0] w;
    c0 = acc_cnt;
    w = mk_word(0, 1);
    for (int i = 15; i >= 8; i--) send_bit(w[i]);
    @(negedge clk); lock = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
    repeat (3) @(negedge clk);
    check("R8 no accept unlocked", acc_cnt - c0, 0);
    check("R8 lines held unlocked", lines, model);
    lock = 1'b1;
    for (int i = 14; i >= 0; i--) send_bit(w[i]);
    repeat (3) @(negedge clk);
    check("R8 fifteen bits not enough", acc_cnt - c0, 0);
    send_word(w); model[0] = 1'b1;
    check("R8 full word after relock", acc_cnt - c0, 1);
    check("R8 lines after relock", lines, model);
  endtask

  task automatic t_nostrobe;
    int c0;
    logic [15:0] w;
    c0 = acc_cnt;
    w = mk_word(3, 1);
    for (int i = 15; i >= 0; i--) begin
      send_bit(w[i]);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); bit_in = ~bit_in;
      end
    end
    repeat (3) @(negedge clk);
    model[3] = 1'b1;
    check("R9 idle bit_in ignored accept", acc_cnt - c0, 1);
    check("R9 idle bit_in ignored lines", lines, model);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    lock = 1'b1;
    @(negedge clk);
    t_set_clear;
    t_all;
    t_timing;
    t_repeat;
    t_bad_header;
    t_bad_pair;
    t_lock;
    t_nostrobe;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule